// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. A down-counter runs once software sets a sticky enable bit and reloads from one of sixteen power-of-two timeout periods. Software keeps the system alive by writing a fixed key word to a restart location. A restart reloads the counter and withdraws any pending timeout interrupt. When the counter runs out, the block either issues a fixed-width system reset pulse straight away or, in two-stage mode, first raises an interrupt and issues the reset only if a second full period runs out with that interrupt still pending.

A simple 32-bit register bus reaches the block: valid, write, byte address, write data, and read data that is registered. The first count after enable uses a separate initial period index, so boot code can grant a longer first window. Every later reload uses the running period index. After the reset pulse the block freezes until its own reset. A read-only parameter word and two identification words report the fixed configuration.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, reads of the control (0x00), range (0x04), count (0x08) and status (0x10) words return 0, and irq_o and sys_rst_o are low.
- R2: Writing 1 to control bit 0 starts the timer. A later write cannot clear bit 0; only rst_n clears it. Control bit 1 (mode: 0 = reset at once, 1 = interrupt first) can be rewritten at any time, and control reads return {mode, enable} in bits 1:0.
- R3: Index i selects a period of 2^(BASE_SHIFT+i) cycles. The load made at enable uses range bits 7:4 (the initial index).
- R4: While the timer runs, writing exactly 32'h00000076 to 0x0C reloads the counter from range bits 3:0. Any other write value changes nothing.
- R5: The counter drops by one each cycle. In the cycle it holds 0 it expires. In mode 0, sys_rst_o goes high from the next cycle for exactly RST_PULSE cycles, and irq_o stays low.
- R6: In mode 1, an expiry with no interrupt pending raises irq_o and reloads from range bits 3:0. An expiry while irq_o is high starts the reset pulse.
- R7: A key write clears irq_o.
- R8: A read of 0x14 returns the interrupt status and clears irq_o, and the counter is not reloaded.
- R9: A key write in the very cycle of an expiry wins: the counter reloads, and neither an interrupt nor a reset follows from that expiry.
- R10: After the reset pulse the counter holds its value, key writes are ignored and sys_rst_o stays low until rst_n.
- R11: Writes to the range and mode fields never reload the counter. A new period applies from the next reload, and a new mode applies from the next expiry.
- R12: The word at 0xF4 reads 32'h00000040 (bit 6: fixed power-of-two periods). 0xF8 and 0xFC read the VERSION_ID and KIND_ID parameters.
- R13: The read data for a request sampled at one clock edge appears after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus request valid for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Timeout interrupt, level |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The collision that matters is a key write that lands in the same cycle as an expiry. The bench times a restart so that the bus sample falls exactly on the edge where the counter holds zero. It does this once in direct mode, where the expected result is no reset pulse and a count reading back the full period. It does this again in two-stage mode with the interrupt already pending, where the expected result is no reset and irq_o dropping. A second overlap, a status-clear read during a running count, is judged by reading the count back and confirming that it was not reloaded.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned N_PERIODS = 16;
  localparam int unsigned IDX_W     = $clog2(N_PERIODS);

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RANGE = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_KICK  = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_ACK   = 8'h14;
  localparam logic [7:0] OFS_PARAM = 8'hF4;
  localparam logic [7:0] OFS_VER   = 8'hF8;
  localparam logic [7:0] OFS_KIND  = 8'hFC;

  localparam logic [31:0] KICK_KEY   = 32'h0000_0076;
  localparam logic [31:0] PARAM_WORD = 32'h0000_0040;

  typedef enum logic [1:0] {
    RS_RUN   = 2'd0,
    RS_PULSE = 2'd1,
    RS_HALT  = 2'd2
  } resp_state_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_range,
  input  logic [1:0]       ctrl_wdata,
  input  logic [7:0]       range_wdata,
  output logic             en_o,
  output logic             mode_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic [IDX_W-1:0] init_idx_o,
  output logic             en_set_o
);
  logic             en_q, en_d;
  logic             mode_q, mode_d;
  logic [IDX_W-1:0] sel_q, sel_d, init_q, init_d;

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    sel_d  = sel_q;
    init_d = init_q;
    if (wr_ctrl) begin
      en_d   = en_q | ctrl_wdata[0];
      mode_d = ctrl_wdata[1];
    end
    if (wr_range) begin
      sel_d  = range_wdata[IDX_W-1:0];
      init_d = range_wdata[2*IDX_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
      init_q <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
      init_q <= init_d;
    end
  end

  assign en_o       = en_q;
  assign mode_o     = mode_q;
  assign sel_idx_o  = sel_q;
  assign init_idx_o = init_q;
  assign en_set_o   = wr_ctrl & ctrl_wdata[0] & ~en_q;

  assert_en_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned BASE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             en_set_i,
  input  logic             restart_i,
  input  logic [IDX_W-1:0] sel_idx_i,
  input  logic [IDX_W-1:0] init_idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] period_tbl [N_PERIODS];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] sel_period;
  logic             active;

  for (genvar gi = 0; gi < N_PERIODS; gi++) begin : g_period
    assign period_tbl[gi] = CNT_W'(1) << (BASE_SHIFT + gi);
  end

  assign sel_period = period_tbl[sel_idx_i];
  assign active     = run_i & en_i;
  assign expire_o   = active & ~restart_i & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (en_set_i)
      cnt_d = period_tbl[init_idx_i];
    else if (active && (restart_i || cnt_q == '0))
      cnt_d = sel_period;
    else if (active)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && restart_i) |=> (cnt_q == $past(sel_period)));

  assert_frozen_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !en_set_i) |=> $stable(cnt_q));
endmodule

// File: rtl/kwdt_resp.sv
module kwdt_resp
  import kwdt_pkg::*;
#(
  parameter int unsigned RST_PULSE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic mode_i,
  input  logic restart_i,
  input  logic ack_i,
  output logic run_o,
  output logic irq_o,
  output logic sys_rst_o
);
  localparam int unsigned PW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;

  resp_state_e   state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          irq_q, irq_d;
  logic          fire;

  assign fire = expire_i & (~mode_i | irq_q);

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    irq_d   = irq_q;
    unique case (state_q)
      RS_RUN: begin
        if (restart_i)                       irq_d = 1'b0;
        else if (expire_i && mode_i && !irq_q) irq_d = 1'b1;
        else if (ack_i)                      irq_d = 1'b0;
        if (fire) begin
          state_d = RS_PULSE;
          pcnt_d  = PW'(RST_PULSE - 1);
        end
      end
      RS_PULSE: begin
        if (pcnt_q == '0) state_d = RS_HALT;
        else              pcnt_d  = pcnt_q - 1'b1;
      end
      default: state_d = RS_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_RUN;
      pcnt_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      irq_q   <= irq_d;
    end
  end

  assign run_o     = (state_q == RS_RUN);
  assign irq_o     = irq_q;
  assign sys_rst_o = (state_q == RS_PULSE);

  assert_rst_after_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(expire_i));

  assert_first_expiry_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && expire_i && mode_i && !irq_q) |=> (irq_o && !sys_rst_o));

  assert_kick_clears_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && restart_i) |=> !irq_o);

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_HALT) |=> (!sys_rst_o && state_q == RS_HALT));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned BASE_SHIFT = 16,
  parameter int unsigned RST_PULSE  = 8,
  parameter logic [31:0] VERSION_ID = 32'h0001_0200,
  parameter logic [31:0] KIND_ID    = 32'h4B57_0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        sys_rst_o
);
  logic             sync1_q, rst_ni;
  logic             wr, rd, wr_ctrl, wr_range, restart, ack;
  logic             en, mode, en_set, run, expire;
  logic [IDX_W-1:0] sel_idx, init_idx;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      rdata_d, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_ni  <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_ni  <= sync1_q;
    end
  end

  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign wr_ctrl  = wr & (bus_addr == OFS_CTRL);
  assign wr_range = wr & (bus_addr == OFS_RANGE);
  assign restart  = wr & (bus_addr == OFS_KICK) & (bus_wdata == KICK_KEY);
  assign ack      = rd & (bus_addr == OFS_ACK);

  kwdt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_ctrl    (wr_ctrl),
    .wr_range   (wr_range),
    .ctrl_wdata (bus_wdata[1:0]),
    .range_wdata(bus_wdata[7:0]),
    .en_o       (en),
    .mode_o     (mode),
    .sel_idx_o  (sel_idx),
    .init_idx_o (init_idx),
    .en_set_o   (en_set)
  );

  kwdt_counter #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_counter (
    .clk       (clk),
    .rst_n     (rst_ni),
    .run_i     (run),
    .en_i      (en),
    .en_set_i  (en_set),
    .restart_i (restart),
    .sel_idx_i (sel_idx),
    .init_idx_i(init_idx),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  kwdt_resp #(.RST_PULSE(RST_PULSE)) u_resp (
    .clk      (clk),
    .rst_n    (rst_ni),
    .expire_i (expire),
    .mode_i   (mode),
    .restart_i(restart),
    .ack_i    (ack),
    .run_o    (run),
    .irq_o    (irq_o),
    .sys_rst_o(sys_rst_o)
  );

  always_comb begin
    rdata_d = '0;
    unique case (bus_addr)
      OFS_CTRL:  rdata_d = {30'b0, mode, en};
      OFS_RANGE: rdata_d = {24'b0, init_idx, sel_idx};
      OFS_COUNT: rdata_d = 32'(cnt);
      OFS_STAT:  rdata_d = {31'b0, irq_o};
      OFS_ACK:   rdata_d = {31'b0, irq_o};
      OFS_PARAM: rdata_d = PARAM_WORD;
      OFS_VER:   rdata_d = VERSION_ID;
      OFS_KIND:  rdata_d = KIND_ID;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  localparam int unsigned BS  = 4;
  localparam int unsigned PW  = 4;
  localparam logic [31:0] VER = 32'h0000_0107;
  localparam logic [31:0] KND = 32'h0000_0A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_o, sys_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] val; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_seen = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog #(.CNT_W(32), .BASE_SHIFT(BS), .RST_PULSE(PW),
                   .VERSION_ID(VER), .KIND_ID(KND)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o));

  function automatic logic [31:0] period(input int idx);
    return 32'(1) << (BS + idx);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_valid & ~bus_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R13: actual %0h expected none queued", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(bus_rdata, it.val, it.tag);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.val = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset state and constants
    do_reset();
    chk(32'(irq_o), 0, "R1 irq after reset");
    chk(32'(sys_rst_o), 0, "R1 sys_rst after reset");
    bus_rd(8'h00, 0, "R1 ctrl");
    bus_rd(8'h04, 0, "R1 range");
    bus_rd(8'h08, 0, "R1 count");
    bus_rd(8'h10, 0, "R1 status");
    bus_rd(8'hF4, 32'h40, "R12 param");
    bus_rd(8'hF8, VER, "R12 version");
    bus_rd(8'hFC, KND, "R12 kind");

    // direct mode: initial period, key check, pulse, halt
    bus_wr(8'h04, 32'h10);
    bus_rd(8'h04, 32'h10, "R13 range readback");
    bus_wr(8'h00, 32'h1);
    bus_rd(8'h08, period(1), "R3 initial period");
    bus_wr(8'h0C, 32'h75);
    bus_rd(8'h08, period(1) - 2, "R4 wrong key ignored");
    bus_wr(8'h0C, 32'h76);
    tick(16);
    chk(32'(sys_rst_o), 0, "R5 before expiry");
    tick(1);
    chk(32'(sys_rst_o), 1, "R5 pulse start");
    chk(32'(irq_o), 0, "R5 no irq in direct mode");
    tick(3);
    chk(32'(sys_rst_o), 1, "R5 pulse last cycle");
    tick(1);
    chk(32'(sys_rst_o), 0, "R5 pulse end");
    bus_wr(8'h0C, 32'h76);
    bus_rd(8'h08, period(0), "R10 count frozen");
    tick(40);
    chk(32'(sys_rst_o), 0, "R10 stays low");
    bus_rd(8'h08, period(0), "R10 still frozen");
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h00, 32'h1, "R2 enable sticky");

    // two-stage mode
    do_reset();
    bus_wr(8'h00, 32'h3);
    tick(16);
    chk(32'(irq_o), 0, "R6 irq before expiry");
    tick(1);
    chk(32'(irq_o), 1, "R6 first expiry irq");
    chk(32'(sys_rst_o), 0, "R6 no reset first");
    bus_rd(8'h10, 32'h1, "R6 status set");
    bus_wr(8'h0C, 32'h76);
    chk(32'(irq_o), 0, "R7 kick clears irq");
    bus_rd(8'h10, 32'h0, "R7 status clear");
    bus_rd(8'h08, period(0) - 1, "R4 reload sel period");
    tick(15);
    chk(32'(irq_o), 1, "R6 irq again");
    bus_rd(8'h14, 32'h1, "R8 ack returns status");
    chk(32'(irq_o), 0, "R8 ack clears irq");
    bus_rd(8'h08, period(0) - 1, "R8 no reload by ack");
    tick(15);
    chk(32'(irq_o), 1, "R8 next expiry only irq");
    chk(32'(sys_rst_o), 0, "R8 no reset after ack");
    tick(16);
    chk(32'(sys_rst_o), 0, "R6 before second expiry");
    tick(1);
    chk(32'(sys_rst_o), 1, "R6 second expiry reset");

    // collisions and deferred settings
    do_reset();
    bus_wr(8'h00, 32'h1);
    tick(16);
    bus_wr(8'h0C, 32'h76);
    chk(32'(sys_rst_o), 0, "R9 kick wins direct");
    bus_rd(8'h08, period(0), "R9 reload on collision");
    bus_wr(8'h04, 32'h1);
    bus_wr(8'h00, 32'h3);
    bus_rd(8'h00, 32'h3, "R2 mode rewritable");
    bus_rd(8'h08, period(0) - 4, "R11 no reload on write");
    bus_wr(8'h0C, 32'h76);
    bus_rd(8'h08, period(1), "R11 new period at reload");
    tick(32);
    chk(32'(irq_o), 1, "R11 new mode at expiry");
    chk(32'(sys_rst_o), 0, "R11 no reset");
    tick(32);
    bus_wr(8'h0C, 32'h76);
    chk(32'(sys_rst_o), 0, "R9 kick wins pending");
    chk(32'(irq_o), 0, "R9 irq dropped");

    tick(2);
    chk(32'(sb_q.size()), 0, "R13 all reads answered");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule